// File: doc/BRIEF.md
# Converter Power-Up and Mute Sequencer

This block is the control state machine on the digital side of a stereo audio converter. It watches for the master clock and the frame clock and waits for a valid clock-ratio result. It then powers the voltage reference and waits a timed interval while the reference ramps. It lets the modulator out of reset and holds the output muted for a fixed number of sample periods before releasing audio. The analog ramps are not modelled here; each is a timed interval counted in slow timer ticks.

Clock presence is judged inside the block from one-cycle edge strobes. Each strobe feeds a timeout detector that drops its presence flag after a set number of idle cycles. A clock-ratio change, or loss of a valid ratio while audio plays, sends the block back to ratio detection with the output muted. Loss of the frame clock returns it to the wait state. Loss of the master clock starts a timed ramp-down that ends in power-down.

The states and their codes are: OFF (0, power-down), WAIT (1, master clock seen, waiting for frame clock), DETECT (2, ratio detection), REFUP (3, reference ramp), SETTLE (4, converters on, muted, counting samples), RUN (5, audio out) and RAMPDN (6, outputs ramping down). The transitions are power-up (OFF to WAIT or DETECT), frame-found (WAIT to DETECT), ratio-locked (DETECT to REFUP), ref-ready (REFUP to SETTLE), unmute (SETTLE to RUN), re-detect (REFUP, SETTLE or RUN to DETECT), frame-lost (DETECT, REFUP, SETTLE or RUN to WAIT), clock-lost (any state but OFF and RAMPDN to RAMPDN) and ramp-done (RAMPDN to OFF).

Top module: `conv_pwr_seq`

## Requirements
- R1: After reset the state code is OFF (0), the reference enable is low, the modulator reset is high and mute is high. State codes are OFF=0, WAIT=1, DETECT=2, REFUP=3, SETTLE=4, RUN=5, RAMPDN=6.
- R2: OFF is left only when the master clock is present. It goes to DETECT if the frame clock is also present, otherwise to WAIT. WAIT goes to DETECT once the frame clock is present.
- R3: States are reached in the order DETECT, REFUP, SETTLE, RUN. DETECT moves to REFUP only when ratio-valid is high and ratio-changed is low. The reference enable is high exactly in REFUP, SETTLE and RUN. The modulator reset is low exactly in SETTLE and RUN.
- R4: REFUP lasts until RAMP_TICKS timer ticks have been counted in that state, then moves to SETTLE.
- R5: SETTLE moves to RUN after UNMUTE_SAMPLES frame-clock edges seen with ratio-valid high. Mute is low only in RUN.
- R6: While in SETTLE, ratio-valid low restarts the sample count from zero without leaving SETTLE.
- R7: Ratio-changed high in REFUP, SETTLE or RUN, or ratio-valid low in REFUP or RUN, moves to DETECT. Mute is high in the cycle after any ratio-changed pulse.
- R8: Loss of the master clock from WAIT, DETECT, REFUP, SETTLE or RUN moves to RAMPDN, where the reference is off and the output is muted. After RAMP_TICKS ticks RAMPDN moves to OFF.
- R9: Loss of the frame clock while the master clock is present moves DETECT, REFUP, SETTLE or RUN to WAIT.
- R10: A clock is judged present from the cycle after its edge strobe. It is judged absent after MCLK_TIMEOUT or FCLK_TIMEOUT cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_edge_i | input | 1 | One-cycle strobe per master-clock edge |
| fclk_edge_i | input | 1 | One-cycle strobe per frame-clock period (one sample) |
| ratio_ok_i | input | 1 | Clock-ratio detector holds a valid result |
| ratio_chg_i | input | 1 | Clock-ratio detector saw a ratio or rate change |
| tick_i | input | 1 | Slow timer tick for the ramp intervals |
| state_o | output | 3 | Current state code |
| ref_en_o | output | 1 | Reference power enable |
| mod_rst_o | output | 1 | Filter and modulator reset, active high |
| mute_o | output | 1 | Forces zero output data when high |

## Verification
Several rules are checked on every cycle. OFF is held without a master clock. Losing the master clock forces RAMPDN, and losing the frame clock forces WAIT. A ratio change is muted by the next cycle. The reference only switches on leaving DETECT, mute only falls on leaving SETTLE, and a strobe always sets its presence flag. Other behaviour only shows over a whole scenario. This covers the exact tick count of each ramp, the exact sample count before unmute, and the restart of that count when the ratio drops. It also covers the full walk from power-down to audio and back, which the bench's step table and directed tests run through.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF    = 3'd0,
        SQ_WAIT   = 3'd1,
        SQ_DETECT = 3'd2,
        SQ_REFUP  = 3'd3,
        SQ_SETTLE = 3'd4,
        SQ_RUN    = 3'd5,
        SQ_RAMPDN = 3'd6
    } seq_state_t;

endpackage

// File: rtl/clk_presence.sv
module clk_presence #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic present_o
);
    localparam int W = $clog2(TIMEOUT + 1);

    logic [W-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q    <= '0;
            present_o <= 1'b0;
        end else if (edge_i) begin
            idle_q    <= '0;
            present_o <= 1'b1;
        end else if (present_o) begin
            if (idle_q == W'(TIMEOUT - 1)) begin
                idle_q    <= '0;
                present_o <= 1'b0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R10: a strobe always makes the clock present next cycle
    a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> present_o);

    // R10: presence only drops after a cycle with no strobe
    a_r10_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(present_o) |-> !$past(edge_i));

endmodule

// File: rtl/span_counter.sv
module span_counter #(
    parameter int LIMIT = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt_q;

    assign hit_o = inc_i && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: the interval count never passes its limit
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT - 1));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_ok,
    input  logic       fclk_ok,
    input  logic       ratio_ok,
    input  logic       ratio_chg,
    input  logic       ramp_done,
    input  logic       unmute_done,
    output seq_state_t state_o,
    output logic       change_o,
    output logic       ref_en_o,
    output logic       mod_rst_o,
    output logic       mute_o
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_OFF: begin
                if (mclk_ok) st_d = fclk_ok ? SQ_DETECT : SQ_WAIT;
            end
            SQ_WAIT: begin
                if (!mclk_ok)     st_d = SQ_RAMPDN;
                else if (fclk_ok) st_d = SQ_DETECT;
            end
            SQ_DETECT: begin
                if (!mclk_ok)                    st_d = SQ_RAMPDN;
                else if (!fclk_ok)               st_d = SQ_WAIT;
                else if (ratio_ok && !ratio_chg) st_d = SQ_REFUP;
            end
            SQ_REFUP: begin
                if (!mclk_ok)                    st_d = SQ_RAMPDN;
                else if (!fclk_ok)               st_d = SQ_WAIT;
                else if (ratio_chg || !ratio_ok) st_d = SQ_DETECT;
                else if (ramp_done)              st_d = SQ_SETTLE;
            end
            SQ_SETTLE: begin
                if (!mclk_ok)         st_d = SQ_RAMPDN;
                else if (!fclk_ok)    st_d = SQ_WAIT;
                else if (ratio_chg)   st_d = SQ_DETECT;
                else if (unmute_done) st_d = SQ_RUN;
            end
            SQ_RUN: begin
                if (!mclk_ok)                    st_d = SQ_RAMPDN;
                else if (!fclk_ok)               st_d = SQ_WAIT;
                else if (ratio_chg || !ratio_ok) st_d = SQ_DETECT;
            end
            SQ_RAMPDN: begin
                if (ramp_done) st_d = SQ_OFF;
            end
            default: st_d = SQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        state_o   = st_q;
        change_o  = (st_d != st_q);
        ref_en_o  = 1'b0;
        mod_rst_o = 1'b1;
        mute_o    = 1'b1;
        unique case (st_q)
            SQ_REFUP:  ref_en_o = 1'b1;
            SQ_SETTLE: begin
                ref_en_o  = 1'b1;
                mod_rst_o = 1'b0;
            end
            SQ_RUN: begin
                ref_en_o  = 1'b1;
                mod_rst_o = 1'b0;
                mute_o    = 1'b0;
            end
            default: ;
        endcase
    end

    // R2: power-down holds without a master clock
    a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_OFF && !mclk_ok) |=> st_q == SQ_OFF);

    // R3: the reference switches on only when leaving ratio detection
    a_r3_ref_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en_o) |-> $past(st_q) == SQ_DETECT);

    // R5: mute is released only when leaving the settle interval
    a_r5_unmute_src: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute_o) |-> $past(st_q) == SQ_SETTLE);

    // R7: a ratio change is muted by the next cycle
    a_r7_chg_mute: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_chg |=> mute_o);

    // R8: master-clock loss starts the ramp-down
    a_r8_mclk_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclk_ok && st_q != SQ_OFF && st_q != SQ_RAMPDN) |=> st_q == SQ_RAMPDN);

    // R9: frame-clock loss returns to the wait state
    a_r9_fclk_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_ok && !fclk_ok &&
         (st_q == SQ_DETECT || st_q == SQ_REFUP || st_q == SQ_SETTLE || st_q == SQ_RUN))
        |=> st_q == SQ_WAIT);

endmodule

// File: rtl/conv_pwr_seq.sv
module conv_pwr_seq
    import conv_seq_pkg::*;
#(
    parameter int MCLK_TIMEOUT   = 64,
    parameter int FCLK_TIMEOUT   = 4096,
    parameter int RAMP_TICKS     = 250,
    parameter int UNMUTE_SAMPLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_edge_i,
    input  logic       fclk_edge_i,
    input  logic       ratio_ok_i,
    input  logic       ratio_chg_i,
    input  logic       tick_i,
    output logic [2:0] state_o,
    output logic       ref_en_o,
    output logic       mod_rst_o,
    output logic       mute_o
);
    logic       mclk_ok, fclk_ok;
    logic       ramp_hit, smp_hit;
    logic       st_change;
    seq_state_t st;

    clk_presence #(.TIMEOUT(MCLK_TIMEOUT)) u_mclk_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (mclk_edge_i),
        .present_o (mclk_ok)
    );

    clk_presence #(.TIMEOUT(FCLK_TIMEOUT)) u_fclk_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (fclk_edge_i),
        .present_o (fclk_ok)
    );

    logic in_ramp;
    logic in_settle;
    assign in_ramp   = (st == SQ_REFUP) || (st == SQ_RAMPDN);
    assign in_settle = (st == SQ_SETTLE);

    span_counter #(.LIMIT(RAMP_TICKS)) u_ramp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (st_change || !in_ramp),
        .inc_i (tick_i && in_ramp),
        .hit_o (ramp_hit)
    );

    span_counter #(.LIMIT(UNMUTE_SAMPLES)) u_smp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (!in_settle || !ratio_ok_i),
        .inc_i (fclk_edge_i && in_settle && ratio_ok_i),
        .hit_o (smp_hit)
    );

    seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mclk_ok     (mclk_ok),
        .fclk_ok     (fclk_ok),
        .ratio_ok    (ratio_ok_i),
        .ratio_chg   (ratio_chg_i),
        .ramp_done   (ramp_hit),
        .unmute_done (smp_hit),
        .state_o     (st),
        .change_o    (st_change),
        .ref_en_o    (ref_en_o),
        .mod_rst_o   (mod_rst_o),
        .mute_o      (mute_o)
    );

    assign state_o = st;

endmodule

// File: tb/sim_conv_pwr_seq.sv
module sim_conv_pwr_seq;
    localparam int RT = 4;
    localparam int US = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_run = 1'b0, fclk_run = 1'b0, rok = 1'b0, rchg = 1'b0;
    logic mclk_edge = 1'b0, fclk_edge = 1'b0, tick = 1'b0;
    logic [2:0] state;
    logic ref_en, mod_rst, mute;
    int checks = 0;
    int fails = 0;
    int fdiv = 0;
    int tdiv = 0;

    always #5 clk = ~clk;

    conv_pwr_seq #(.MCLK_TIMEOUT(8), .FCLK_TIMEOUT(32),
                   .RAMP_TICKS(RT), .UNMUTE_SAMPLES(US)) u0 (
        .clk(clk), .rst_n(rst_n), .mclk_edge_i(mclk_edge), .fclk_edge_i(fclk_edge),
        .ratio_ok_i(rok), .ratio_chg_i(rchg), .tick_i(tick),
        .state_o(state), .ref_en_o(ref_en), .mod_rst_o(mod_rst), .mute_o(mute));

    always @(posedge clk) begin
        fdiv <= (fdiv == 9) ? 0 : fdiv + 1;
        tdiv <= (tdiv == 15) ? 0 : tdiv + 1;
        mclk_edge <= mclk_run;
        fclk_edge <= fclk_run && (fdiv == 0);
        tick <= (tdiv == 0);
    end

    typedef struct packed {
        logic        m;
        logic        f;
        logic        ok;
        logic        chg;
        logic [15:0] cyc;
        logic [2:0]  exp_st;
    } step_t;

    localparam step_t STEPS [13] = '{
        '{1'b0,1'b0,1'b0,1'b0,16'd30, 3'd0},  // R2 no clocks: OFF
        '{1'b1,1'b0,1'b0,1'b0,16'd30, 3'd1},  // R2 master only: WAIT
        '{1'b1,1'b1,1'b0,1'b0,16'd60, 3'd2},  // R2 both clocks: DETECT
        '{1'b1,1'b1,1'b1,1'b0,16'd20, 3'd3},  // R3 ratio valid: REFUP
        '{1'b1,1'b1,1'b1,1'b0,16'd80, 3'd4},  // R4 ramp over: SETTLE
        '{1'b1,1'b1,1'b1,1'b0,16'd100,3'd5},  // R5 samples counted: RUN
        '{1'b1,1'b1,1'b1,1'b1,16'd5,  3'd2},  // R7 ratio change: DETECT
        '{1'b1,1'b1,1'b0,1'b0,16'd10, 3'd2},  // R7 no valid ratio: DETECT
        '{1'b1,1'b1,1'b1,1'b0,16'd200,3'd5},  // R3 back to RUN
        '{1'b1,1'b0,1'b1,1'b0,16'd50, 3'd1},  // R9 frame lost: WAIT
        '{1'b1,1'b1,1'b1,1'b0,16'd250,3'd5},  // R9 recover to RUN
        '{1'b0,1'b0,1'b1,1'b0,16'd20, 3'd6},  // R8 master lost: RAMPDN
        '{1'b0,1'b0,1'b1,1'b0,16'd80, 3'd0}   // R8 ramp done: OFF
    };

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic chk_outs(input string req, input int st);
        chk({req, " state"}, state, st);
        chk({req, " ref_en"}, ref_en, (st == 3 || st == 4 || st == 5) ? 1 : 0);
        chk({req, " mod_rst"}, mod_rst, (st == 4 || st == 5) ? 0 : 1);
        chk({req, " mute"}, mute, (st == 5) ? 0 : 1);
    endtask

    task automatic wait_state(input int st);
        for (int i = 0; i < 2000 && state != 3'(st); i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk_outs("R1 reset", 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 after release", 0);

        for (int s = 0; s < 13; s++) begin
            mclk_run = STEPS[s].m;
            fclk_run = STEPS[s].f;
            rok      = STEPS[s].ok;
            rchg     = STEPS[s].chg;
            for (int c = 0; c < int'(STEPS[s].cyc); c++) @(negedge clk);
            chk_outs($sformatf("step%0d", s), int'(STEPS[s].exp_st));
        end

        // R4: reference ramp counts exactly RT ticks
        mclk_run = 1; fclk_run = 1; rok = 1; rchg = 0;
        wait_state(3);
        n = 0;
        for (int i = 0; i < 2000 && state == 3'd3; i++) begin
            if (tick) n++;
            @(negedge clk);
        end
        chk("R4 ramp ticks", n, RT);
        chk("R4 next state", state, 4);

        // R5: settle counts exactly US frame edges
        n = 0;
        for (int i = 0; i < 2000 && state == 3'd4; i++) begin
            if (fclk_edge) n++;
            @(negedge clk);
        end
        chk("R5 unmute samples", n, US);
        chk_outs("R5 in RUN", 5);

        // R6: ratio-valid drop restarts the sample count
        rok = 0; repeat (5) @(negedge clk);
        rok = 1;
        wait_state(4);
        repeat (50) @(negedge clk);
        rok = 0; repeat (20) @(negedge clk);
        chk("R6 stays SETTLE while invalid", state, 4);
        rok = 1; repeat (60) @(negedge clk);
        chk("R6 count restarted", state, 4);
        chk("R6 still muted", mute, 1);
        repeat (40) @(negedge clk);
        chk("R6 unmute after full count", state, 5);

        // R7: change during REFUP falls back to DETECT
        rchg = 1; @(negedge clk); rchg = 0;
        wait_state(3);
        rchg = 1; @(negedge clk);
        chk("R7 refup change", state, 2);
        rchg = 0;

        // R8: ramp-down counts exactly RT ticks
        wait_state(5);
        mclk_run = 0; fclk_run = 0;
        wait_state(6);
        chk_outs("R8 ramp-down outputs", 6);
        n = 0;
        for (int i = 0; i < 2000 && state == 3'd6; i++) begin
            if (tick) n++;
            @(negedge clk);
        end
        chk("R8 ramp-down ticks", n, RT);
        chk_outs("R8 back to OFF", 0);

        // R10: master presence expires after the timeout
        mclk_run = 1; @(negedge clk); mclk_run = 0;
        repeat (3) @(negedge clk);
        chk("R10 present after strobe", state, 1);
        repeat (30) @(negedge clk);
        chk("R10 timeout to RAMPDN", state, 6);
        wait_state(0);

        // R1: reset in RUN returns to OFF
        mclk_run = 1; fclk_run = 1; rok = 1;
        wait_state(5);
        rst_n = 0; @(negedge clk);
        chk_outs("R1 reset from RUN", 0);
        rst_n = 1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule